// File: doc/BRIEF.md
# Clock Rate Controller with Switchback

This block sets how many oscillator clocks make up one machine cycle. It emits a single-clock enable pulse at the chosen rate. Software writes a 2-bit divide code that picks the normal fast rate or one of two slow power-saving rates. A new rate takes hold only at the end of the machine cycle in progress, so no cycle is ever cut short.

When automatic switchback is armed, an external interrupt that is both pending and enabled sends the block back to the fast rate. Software does not have to act. The readable divide code then shows the fast code. A separate source-select flag chooses between the crystal and the ring oscillator, and the crystal is the reset choice. The block only accepts a move to the ring while a slow rate is programmed. It produces only select and enable levels; the oscillator circuits are outside it.

Top module: `crc_clock_rate`

## Requirements
- R1: After reset `div_code_o` is 00, `div_act_o` is 00, `ring_sel_o` is 0, and the first `cyc_en_o` pulse comes FAST-1 rising edges after reset is released.
- R2: The effective code in `div_act_o` sets the machine cycle length: 00 or 01 give FAST clocks, 10 gives MID clocks and 11 gives SLOW clocks. `cyc_en_o` is high for exactly one clock in each machine cycle.
- R3: A write (`wr_div_i` high for one clock) loads `div_code_i` into `div_code_o` on that edge.
- R4: A rate change takes effect only at a machine-cycle boundary. The cycle in progress completes at its old length, and `div_act_o` changes only on the edge that ends a cycle.
- R5: If `swb_en_i` is 1 and, for some bit i, `ext_irq_i[i]` and `ext_irq_en_i[i]` are both 1, then `div_code_o` becomes 00 on that edge. The next full machine cycle is FAST clocks long.
- R6: If `swb_en_i` is 0, or if no interrupt bit is both pending and enabled, interrupt inputs leave `div_code_o` and the rate unchanged.
- R7: When a switchback and a software write occur on the same edge, the switchback wins and `div_code_o` becomes 00.
- R8: A write with `wr_src_i`=1 and `src_ring_i`=1 sets `ring_sel_o` only while `div_code_o[1]` is 1; otherwise it is ignored. A write with `src_ring_i`=0 always selects the crystal (`ring_sel_o`=0).
- R9: Divide-code writes do not change `ring_sel_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_div_i | input | 1 | Divide-code write strobe |
| div_code_i | input | 2 | Divide code to write |
| wr_src_i | input | 1 | Source-select write strobe |
| src_ring_i | input | 1 | Source to write: 1 ring, 0 crystal |
| swb_en_i | input | 1 | Automatic switchback enable |
| ext_irq_i | input | N_EXT | External interrupt requests |
| ext_irq_en_i | input | N_EXT | External interrupt enables |
| cyc_en_o | output | 1 | Machine-cycle enable pulse |
| div_code_o | output | 2 | Readable divide code |
| div_act_o | output | 2 | Divide code currently in effect |
| ring_sel_o | output | 1 | Ring oscillator selected (0 = crystal) |

## Verification
The bench builds the block with FAST=4, MID=8, SLOW=16 and N_EXT=2. With these values every slow cycle lasts only a few clocks. That makes all 16 from/to code transitions affordable, each checked across the cycle in progress and the cycle after it. It also allows all 32 combinations of interrupt request, interrupt enable and switchback enable, and a source write under each of the four codes.

// File: rtl/crc_pkg.sv
package crc_pkg;
  typedef enum logic [1:0] {
    DIV_FAST_A = 2'b00,
    DIV_FAST_B = 2'b01,
    DIV_MID    = 2'b10,
    DIV_SLOW   = 2'b11
  } div_code_e;
endpackage

// File: rtl/crc_rate_reg.sv
module crc_rate_reg
  import crc_pkg::*;
#(
  parameter int N_EXT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_div_i,
  input  logic [1:0]       div_code_i,
  input  logic             swb_en_i,
  input  logic [N_EXT-1:0] ext_irq_i,
  input  logic [N_EXT-1:0] ext_irq_en_i,
  output logic [1:0]       div_code_o
);
  logic [N_EXT-1:0] qual;
  logic             swb_hit;

  for (genvar i = 0; i < N_EXT; i++) begin : g_qual
    assign qual[i] = ext_irq_i[i] & ext_irq_en_i[i];
  end

  assign swb_hit = swb_en_i & (|qual);

  // switchback has priority over a software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       div_code_o <= DIV_FAST_A;
    else if (swb_hit)  div_code_o <= DIV_FAST_A;
    else if (wr_div_i) div_code_o <= div_code_i;
  end
endmodule

// File: rtl/crc_cycle_gen.sv
module crc_cycle_gen
  import crc_pkg::*;
#(
  parameter int FAST = 4,
  parameter int MID  = 64,
  parameter int SLOW = 1024,
  localparam int CW  = $clog2(SLOW)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] code_i,
  output logic       cyc_en_o,
  output logic [1:0] act_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  always_comb begin
    unique case (act_o)
      DIV_MID:  last = CW'(MID - 1);
      DIV_SLOW: last = CW'(SLOW - 1);
      default:  last = CW'(FAST - 1);
    endcase
  end

  assign cyc_en_o = (cnt_q == last);

  // new rate adopted only when a cycle ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_o <= DIV_FAST_A;
    end else if (cyc_en_o) begin
      cnt_q <= '0;
      act_o <= code_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/crc_src_sel.sv
module crc_src_sel (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_src_i,
  input  logic       src_ring_i,
  input  logic [1:0] div_code_i,
  output logic       ring_sel_o
);
  logic slow_ok;
  assign slow_ok = div_code_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        ring_sel_o <= 1'b0;
    else if (wr_src_i && !src_ring_i)   ring_sel_o <= 1'b0;
    else if (wr_src_i && slow_ok)       ring_sel_o <= 1'b1;
  end
endmodule

// File: rtl/crc_clock_rate.sv
module crc_clock_rate #(
  parameter int FAST  = 4,
  parameter int MID   = 64,
  parameter int SLOW  = 1024,
  parameter int N_EXT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_div_i,
  input  logic [1:0]       div_code_i,
  input  logic             wr_src_i,
  input  logic             src_ring_i,
  input  logic             swb_en_i,
  input  logic [N_EXT-1:0] ext_irq_i,
  input  logic [N_EXT-1:0] ext_irq_en_i,
  output logic             cyc_en_o,
  output logic [1:0]       div_code_o,
  output logic [1:0]       div_act_o,
  output logic             ring_sel_o
);
  crc_rate_reg #(.N_EXT(N_EXT)) u_rate (
    .clk_i, .rst_ni, .wr_div_i, .div_code_i, .swb_en_i,
    .ext_irq_i, .ext_irq_en_i, .div_code_o
  );

  crc_cycle_gen #(.FAST(FAST), .MID(MID), .SLOW(SLOW)) u_cyc (
    .clk_i, .rst_ni, .code_i(div_code_o), .cyc_en_o, .act_o(div_act_o)
  );

  crc_src_sel u_src (
    .clk_i, .rst_ni, .wr_src_i, .src_ring_i,
    .div_code_i(div_code_o), .ring_sel_o
  );
endmodule

// File: rtl/crc_clock_rate_chk.sv
module crc_clock_rate_chk #(
  parameter int FAST  = 4,
  parameter int MID   = 64,
  parameter int SLOW  = 1024,
  parameter int N_EXT = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_src_i,
  input logic             src_ring_i,
  input logic             swb_en_i,
  input logic [N_EXT-1:0] ext_irq_i,
  input logic [N_EXT-1:0] ext_irq_en_i,
  input logic             cyc_en_o,
  input logic [1:0]       div_code_o,
  input logic [1:0]       div_act_o,
  input logic             ring_sel_o
);
  int unsigned gap_q;
  int unsigned want;

  always_comb begin
    unique case (div_act_o)
      2'b10:   want = MID - 1;
      2'b11:   want = SLOW - 1;
      default: want = FAST - 1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       gap_q <= 0;
    else if (cyc_en_o) gap_q <= 0;
    else               gap_q <= gap_q + 1;
  end

  a_r2_cycle_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_en_o |-> gap_q == want);

  a_r4_boundary_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_en_o |=> $stable(div_act_o));

  a_r5_switchback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swb_en_i && |(ext_irq_i & ext_irq_en_i)) |=> div_code_o == 2'b00);

  a_r8_ring_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_src_i && src_ring_i && !div_code_o[1] && !ring_sel_o) |=> !ring_sel_o);

  a_r8_crystal_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_src_i && !src_ring_i) |=> !ring_sel_o);
endmodule

bind crc_clock_rate crc_clock_rate_chk #(
  .FAST(FAST), .MID(MID), .SLOW(SLOW), .N_EXT(N_EXT)
) u_chk (
  .clk_i, .rst_ni, .wr_src_i, .src_ring_i, .swb_en_i, .ext_irq_i,
  .ext_irq_en_i, .cyc_en_o, .div_code_o, .div_act_o, .ring_sel_o
);

// File: tb/crc_clock_rate_test.sv
module crc_clock_rate_test;
  localparam int FAST = 4, MID = 8, SLOW = 16, N_EXT = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_div = 0, wr_src = 0, src_ring = 0, swb_en = 0;
  logic [1:0] div_code = 0;
  logic [N_EXT-1:0] irq = 0, irq_en = 0;
  logic cyc_en, ring_sel;
  logic [1:0] code_rd, act;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  crc_clock_rate #(.FAST(FAST), .MID(MID), .SLOW(SLOW), .N_EXT(N_EXT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_div_i(wr_div), .div_code_i(div_code),
    .wr_src_i(wr_src), .src_ring_i(src_ring), .swb_en_i(swb_en),
    .ext_irq_i(irq), .ext_irq_en_i(irq_en), .cyc_en_o(cyc_en),
    .div_code_o(code_rd), .div_act_o(act), .ring_sel_o(ring_sel)
  );

  function automatic int ratio(input logic [1:0] c);
    return c == 2'b11 ? SLOW : (c == 2'b10 ? MID : FAST);
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!cyc_en);
  endtask

  // call while at a pulse negedge; returns clocks to the next pulse
  task automatic interval(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!cyc_en);
  endtask

  task automatic set_code(input logic [1:0] c, input logic [1:0] old);
    int n;
    wait_pulse();
    wr_div = 1; div_code = c;
    @(negedge clk); wr_div = 0;
    check("R3 readback", code_rd, c);
    n = 1;
    while (!cyc_en) begin @(negedge clk); n++; end
    check("R4 old length finishes", n, ratio(old));
    interval(n);
    check("R2 new length", n, ratio(c));
  endtask

  task automatic write_src(input logic r);
    wr_src = 1; src_ring = r;
    @(negedge clk); wr_src = 0;
  endtask

  initial begin
    int n;
    logic [1:0] cur;
    logic hit;
    repeat (3) @(negedge clk);
    check("R1 code", code_rd, 0);
    check("R1 act", act, 0);
    check("R1 ring", ring_sel, 0);
    rst_n = 1;
    n = 0;
    while (!cyc_en) begin @(negedge clk); n++; end
    check("R1 first pulse", n, FAST - 1);
    interval(n);
    check("R2 reset rate", n, FAST);

    // R2 R3 R4: all transitions
    cur = 0;
    for (int f = 0; f < 4; f++)
      for (int t = 0; t < 4; t++) begin
        set_code(2'(f), cur); cur = 2'(f);
        set_code(2'(t), cur); cur = 2'(t);
      end

    // R5 R6: switchback sweep
    for (int s = 0; s < 2; s++)
      for (int q = 0; q < 4; q++)
        for (int e = 0; e < 4; e++) begin
          set_code(2'b11, cur); cur = 2'b11;
          swb_en = s[0]; irq = 2'(q); irq_en = 2'(e);
          @(negedge clk);
          swb_en = 0; irq = 0; irq_en = 0;
          hit = s[0] && ((q & e) != 0);
          check(hit ? "R5 code cleared" : "R6 code kept", code_rd, hit ? 0 : 3);
          wait_pulse(); interval(n);
          check(hit ? "R5 fast rate" : "R6 slow rate", n, hit ? FAST : SLOW);
          cur = hit ? 2'b00 : 2'b11;
        end

    // R7: simultaneous write and switchback
    set_code(2'b11, cur);
    swb_en = 1; irq = 2'b10; irq_en = 2'b10; wr_div = 1; div_code = 2'b10;
    @(negedge clk);
    swb_en = 0; irq = 0; irq_en = 0; wr_div = 0;
    check("R7 switchback wins", code_rd, 0);
    cur = 0;

    // R8 R9: source select under each code
    for (int c = 0; c < 4; c++) begin
      set_code(2'(c), cur); cur = 2'(c);
      write_src(1);
      check("R8 ring gate", ring_sel, c >= 2 ? 1 : 0);
      set_code(2'(c ^ 1), cur); cur = 2'(c ^ 1);
      check("R9 source kept", ring_sel, c >= 2 ? 1 : 0);
      write_src(0);
      check("R8 crystal write", ring_sel, 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule